// File: doc/BRIEF.md
# Key-Locked Reset Watchdog

This block is a countdown watchdog held inside a power-management device and reached over a simple single-cycle register port. Software sets a 32-bit countdown as two 16-bit halves, then starts the counter with a run bit. The counter takes one step down for each cycle on which the slow tick enable is high. When the count runs out, the block either sends a one-cycle system reset request or, if reset mode is off, sets a sticky expiry flag.

The configuration is guarded against stray writes. The load halves and the control register take a write only while the guard is open. Software opens the guard by writing a fixed 16-bit key to the lock register. Any other value written there closes it again. Reads are always allowed. The register port is plain control with no back-pressure: a write is taken in the cycle `wr_en` is high, and `rdata` follows `addr` combinationally.

Top module: `kwd_watchdog`

## Requirements
- R1: After reset the guard is closed, all registers read 0, and `sys_rst_req` and `expired` are low.
- R2: Writing 0xE551 to offset 0xA0 opens the guard from the next cycle. Writing any other value there closes it. Bit 0 of offset 0xA0 and the `unlocked` pin both show the guard state.
- R3: While the guard is closed, writes to offsets 0x80, 0x84 and 0x88 have no effect.
- R4: Reads work at any time. Offset 0x80 returns the low load half, 0x84 the high half, and 0x88 the control register: bit 1 run, bit 2 mode, bit 3 reset enable, all other bits 0. Unmapped offsets return 0.
- R5: When the run bit goes from 0 to 1, the counter loads the value {high, low}. Expiry then happens on the Nth tick after the start, where N is the load value. A load of 0 expires on the first tick.
- R6: If reset enable is set at expiry, `sys_rst_req` is high for exactly one cycle, in the cycle after the edge that samples the expiring tick, and the run bit reads back 0.
- R7: If reset enable is clear at expiry, `expired` goes high and stays high, no reset request is made, the run bit stays 1 and the counter stops. The next start clears `expired`.
- R8: Clearing the run bit before expiry stops the countdown, and no expiry follows.
- R9: Ticks are ignored while the run bit is 0, including ticks that arrive before a start.
- R10: Writing run=1 while the counter is already running does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable from the slow time base |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| unlocked | output | 1 | Guard open |
| expired | output | 1 | Sticky expiry flag (reset mode off) |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle the assertions check that:
- the reset request lasts a single cycle, needs reset enable, and leaves the run bit clear;
- the key and non-key writes open and close the guard;
- the load and mode fields stay fixed while the guard is closed;
- the sticky flag holds until a restart.

The exact tick on which expiry lands can only be shown by the bench's scenarios. This covers the zero load, a load that uses the high half, and random loads with uneven tick spacing. The same holds for the effect of stopping the counter, restarting it, and writing run again while it is running.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int OFS_LOAD_LO = 'h80;
  localparam int OFS_LOAD_HI = 'h84;
  localparam int OFS_CTRL    = 'h88;
  localparam int OFS_LOCK    = 'hA0;
  localparam int BIT_RUN     = 1;
  localparam int BIT_MODE    = 2;
  localparam int BIT_RSTEN   = 3;

  typedef struct packed {
    logic run;
    logic mode;
    logic rst_en;
  } kwd_ctrl_t;
endpackage

// File: rtl/kwd_lock.sv
module kwd_lock #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY = 16'hE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  import kwd_pkg::*;
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked <= 1'b0;
    else if (wr_en && addr == A_LOCK) unlocked <= (wdata == KEY);
  end
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                unlocked,
  input  logic                stop_run,
  output logic [DATA_W-1:0]   load_lo,
  output logic [DATA_W-1:0]   load_hi,
  output kwd_pkg::kwd_ctrl_t  ctrl,
  output logic                start,
  output logic [DATA_W-1:0]   rdata
);
  import kwd_pkg::*;
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_LOAD_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_LOAD_HI);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);

  logic wr_ok, wr_ctrl;
  assign wr_ok   = wr_en && unlocked;
  assign wr_ctrl = wr_ok && addr == A_CTRL;
  assign start   = wr_ctrl && wdata[BIT_RUN] && !ctrl.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_lo <= '0;
      load_hi <= '0;
      ctrl    <= '0;
    end else begin
      if (wr_ok && addr == A_LO) load_lo <= wdata;
      if (wr_ok && addr == A_HI) load_hi <= wdata;
      if (wr_ctrl) begin
        ctrl.run    <= wdata[BIT_RUN];
        ctrl.mode   <= wdata[BIT_MODE];
        ctrl.rst_en <= wdata[BIT_RSTEN];
      end
      if (stop_run) ctrl.run <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_LO:   rdata = load_lo;
      A_HI:   rdata = load_hi;
      A_CTRL: begin
        rdata[BIT_RUN]   = ctrl.run;
        rdata[BIT_MODE]  = ctrl.mode;
        rdata[BIT_RSTEN] = ctrl.rst_en;
      end
      A_LOCK: rdata[0] = unlocked;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             start,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] load,
  output logic             hit,
  output logic             sys_rst_req,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic             done;

  assign hit = run && !start && tick && !done && (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      done        <= 1'b0;
      expired     <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      sys_rst_req <= hit && rst_en;
      if (start) begin
        cnt     <= load;
        done    <= 1'b0;
        expired <= 1'b0;
      end else if (run && tick && !done) begin
        if (cnt <= CNT_W'(1)) begin
          cnt  <= '0;
          done <= 1'b1;
          if (!rst_en) expired <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY = 16'hE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              unlocked,
  output logic              expired,
  output logic              sys_rst_req
);
  localparam int CNT_W = 2 * DATA_W;

  kwd_pkg::kwd_ctrl_t ctrl;
  logic [DATA_W-1:0]  load_lo, load_hi;
  logic               start, hit, stop_run;
  logic               run_q, mode_q, rsten_q;

  assign run_q    = ctrl.run;
  assign mode_q   = ctrl.mode;
  assign rsten_q  = ctrl.rst_en;
  assign stop_run = hit && ctrl.rst_en;

  kwd_lock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .unlocked(unlocked)
  );

  kwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .unlocked(unlocked), .stop_run(stop_run), .load_lo(load_lo),
    .load_hi(load_hi), .ctrl(ctrl), .start(start), .rdata(rdata)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl.run), .start(start),
    .rst_en(ctrl.rst_en), .load({load_hi, load_lo}), .hit(hit),
    .sys_rst_req(sys_rst_req), .expired(expired)
  );
endmodule

// File: rtl/kwd_watchdog_checker.sv
module kwd_watchdog_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY = 16'hE551
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              unlocked,
  input logic              expired,
  input logic              sys_rst_req,
  input logic              start,
  input logic              run_q,
  input logic              mode_q,
  input logic              rsten_q,
  input logic [DATA_W-1:0] load_lo,
  input logic [DATA_W-1:0] load_hi
);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(kwd_pkg::OFS_LOCK);

  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LOCK && wdata == KEY) |=> unlocked);
  assert_other_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LOCK && wdata != KEY) |=> !unlocked);
  assert_locked_load_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(load_lo) && $stable(load_hi)));
  assert_locked_cfg_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(mode_q) && $stable(rsten_q) && !$rose(run_q)));
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  assert_pulse_needs_rsten_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(rsten_q));
  assert_run_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !run_q);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !start) |=> expired);
endmodule

bind kwd_watchdog kwd_watchdog_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .unlocked(unlocked), .expired(expired), .sys_rst_req(sys_rst_req),
  .start(start), .run_q(run_q), .mode_q(mode_q), .rsten_q(rsten_q),
  .load_lo(load_lo), .load_hi(load_hi)
);

// File: tb/test_kwd_watchdog.sv
module test_kwd_watchdog;
  localparam logic [15:0] KEY = 16'hE551;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic unlocked, expired, sys_rst_req;
  int total = 0, bad = 0;
  bit finished = 0;

  kwd_watchdog i_kwd_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .unlocked(unlocked), .expired(expired),
    .sys_rst_req(sys_rst_req)
  );

  always #2 clk = ~clk;

  function automatic int exp_ticks(logic [15:0] lo, logic [15:0] hi);
    return ({hi, lo} == 32'd0) ? 1 : int'({hi, lo});
  endfunction

  function automatic bit exp_open(logic [15:0] v);
    return v == KEY;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic arm(logic [15:0] lo, logic [15:0] hi, logic [15:0] c);
    wr(8'hA0, KEY); wr(8'h80, lo); wr(8'h84, hi); wr(8'h88, 16'h0000); wr(8'h88, c);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "unlocked", unlocked, 0);
    chk("R1", "sys_rst_req", sys_rst_req, 0);
    chk("R1", "expired", expired, 0);
    rd(8'h88, v); chk("R1", "ctrl", v, 0);
    rd(8'h80, v); chk("R1", "load_lo", v, 0);

    // R3 writes ignored while closed
    wr(8'h80, 16'h1234); wr(8'h84, 16'h0056); wr(8'h88, 16'h000E);
    rd(8'h80, v); chk("R3", "lo locked", v, 0);
    rd(8'h84, v); chk("R3", "hi locked", v, 0);
    rd(8'h88, v); chk("R3", "ctrl locked", v, 0);
    repeat (3) one_tick();
    chk("R3", "no pulse", sys_rst_req, 0);

    // R2 key handling
    wr(8'hA0, KEY);  chk("R2", "open", unlocked, 1);
    rd(8'hA0, v);    chk("R2", "lock readback", v, 1);
    wr(8'hA0, ~KEY); chk("R2", "close inverse", unlocked, 0);
    wr(8'hA0, KEY);  wr(8'hA0, 16'h1234); chk("R2", "close other", unlocked, 0);
    for (int i = 0; i < 30; i++) begin
      logic [15:0] r;
      r = ($urandom % 3 == 0) ? KEY : 16'($urandom);
      wr(8'hA0, r);
      chk("R2", "random key", unlocked, exp_open(r));
    end

    // R4 readback
    wr(8'hA0, KEY); wr(8'h80, 16'hBEEF); wr(8'h84, 16'h0012); wr(8'h88, 16'hFFF4);
    wr(8'hA0, 16'h0000);
    rd(8'h80, v); chk("R4", "lo", v, 16'hBEEF);
    rd(8'h84, v); chk("R4", "hi", v, 16'h0012);
    rd(8'h88, v); chk("R4", "ctrl mode only", v, 16'h0004);
    rd(8'h90, v); chk("R4", "unmapped", v, 0);

    // R9 ticks before start ignored; R5/R6 directed countdown
    arm(16'd2, 16'd0, 16'h0008);
    repeat (3) one_tick();
    wr(8'h88, 16'h000A);
    one_tick(); chk("R9", "no early expiry", sys_rst_req, 0);
    one_tick(); chk("R5", "expiry on tick 2", sys_rst_req, 1);
    @(negedge clk); chk("R6", "single cycle", sys_rst_req, 0);
    rd(8'h88, v); chk("R6", "run cleared", v, 16'h0008);
    repeat (3) one_tick();
    chk("R9", "stopped after expiry", sys_rst_req, 0);

    // R5 zero load
    arm(16'd0, 16'd0, 16'h000A);
    one_tick(); chk("R5", "zero load first tick", sys_rst_req, 1);

    // R7 no reset enable
    arm(16'd3, 16'd0, 16'h0002);
    for (int k = 1; k <= 3; k++) begin
      one_tick();
      chk("R7", "sticky timing", expired, k == 3);
      chk("R7", "no pulse", sys_rst_req, 0);
    end
    repeat (4) one_tick();
    chk("R7", "flag holds", expired, 1);
    chk("R7", "no later pulse", sys_rst_req, 0);
    rd(8'h88, v); chk("R7", "run stays", v, 16'h0002);
    wr(8'h88, 16'h0000); wr(8'h88, 16'h0002);
    chk("R7", "restart clears", expired, 0);

    // R8 stop before expiry
    arm(16'd4, 16'd0, 16'h000A);
    repeat (2) one_tick();
    wr(8'h88, 16'h0008);
    for (int k = 0; k < 6; k++) begin
      one_tick(); chk("R8", "no expiry after stop", sys_rst_req, 0);
    end

    // R10 rewrite of run does not reload
    arm(16'd4, 16'd0, 16'h000A);
    repeat (2) one_tick();
    wr(8'h88, 16'h000A);
    one_tick(); chk("R10", "tick3", sys_rst_req, 0);
    one_tick(); chk("R10", "tick4 expiry", sys_rst_req, 1);

    // R5 high half used: continuous ticks
    begin
      int n;
      arm(16'd2, 16'd1, 16'h000A);
      wr(8'hA0, 16'h0000);
      @(negedge clk); tick = 1; n = 0;
      while (n < 70000) begin
        @(negedge clk); n++;
        if (sys_rst_req) break;
      end
      tick = 0;
      chk("R5", "combined load ticks", n, exp_ticks(16'd2, 16'd1));
    end

    // R5/R6 random loads and gaps
    for (int it = 0; it < 15; it++) begin
      logic [15:0] lo;
      int ne;
      lo = 16'(1 + $urandom % 20);
      ne = exp_ticks(lo, 16'd0);
      arm(lo, 16'd0, 16'h000A);
      wr(8'hA0, 16'($urandom) | 16'h0001 ^ (KEY & 16'h0000));
      for (int k = 1; k <= ne; k++) begin
        repeat ($urandom % 3) @(negedge clk);
        one_tick();
        chk("R6", "random pulse position", sys_rst_req, k == ne);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule